// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches a parallel word of digital inputs and raises one interrupt request when a chosen subset of the input lines meets a programmed condition. Only a contiguous window of channels can interrupt; by default this is bits 19 down to 4 of a 32-bit word. Every input line first passes through a synchroniser. The block then compares the synchronised value against the previous sample to find edges, and against two mask registers to find levels.

Two mask registers, named "up" and "down", select the channels and their polarity. The meaning of the masks depends on the combine mode. In edge-any mode, a selected edge on any enabled channel triggers the request. In level-all mode, the request triggers only when every enabled channel sits at its selected level at the same moment. Once it has fired in level-all mode, the condition must drop and come back before the block can fire again.

At the trigger, a status register captures the window of channel states. Reading the status register clears it. Software acknowledges a request by writing the control word with the enable bit low, and re-arms the block by writing the control word again with the enable bit high. Software accesses the block through a simple single-cycle register bus.

Top module: `cos_irq_ctrl`

## Requirements
- R1: The up-mask register (offset 0x04) and the down-mask register (offset 0x08) keep only the interruptible bits 19:4 of a write. All other bits read back as zero.
- R2: A read at offset 0x00 returns the full synchronised input word.
- R3: In edge-any mode (control bit 2 = 1, bit 1 = 0), a rising edge on a channel whose up-mask bit is set raises irq. A falling edge on a channel whose down-mask bit is set also raises irq.
- R4: In edge-any mode, none of the following raises irq: an edge of the unselected polarity, an edge on an unselected channel, or an edge outside bits 19:4.
- R5: In level-all mode (control bit 2 = 1, bit 1 = 1), irq rises only when every enabled channel meets its level at once. The level is high for an up-mask bit and low for a down-mask bit. A partial match raises nothing.
- R6: In level-all mode, after a trigger the block does not fire again while the condition persists, including across an acknowledge. It fires again only after the condition drops and returns.
- R7: At each trigger, the status register (offset 0x0C) captures input bits 19:4, with all other bits zero. A read of the status register clears it to zero.
- R8: irq stays high from the trigger until a control write with bit 2 low clears it. A later control write with bit 2 high re-arms the block.
- R9: While control bit 2 is low, no input activity raises irq.
- R10: In level-all mode with both masks zero, irq never rises.
- R11: After reset, irq is low and every register reads as zero.
- R12: The control register (offset 0x10) reads back only bits 2:1 of the last write.
- R13: A trigger while a request is pending updates the status register and leaves irq high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pins_in | input | 32 | Asynchronous input lines |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, the channel window at bits 19:4, and a two-stage synchroniser. With this window, the bench can drive an edge on bit 2, just below the window, to show that it is ignored. It can also show that masks written with all ones read back trimmed to the window. The fixed synchroniser depth gives a known latency of three clock edges from a pin change to irq. Every positive and negative check therefore waits a settled number of cycles before it samples.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam logic [7:0] OFS_INPUT  = 8'h00;
  localparam logic [7:0] OFS_UP     = 8'h04;
  localparam logic [7:0] OFS_DOWN   = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  localparam logic [7:0] OFS_CTRL   = 8'h10;
  localparam int CTRL_EN_BIT  = 2;
  localparam int CTRL_AND_BIT = 1;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      q_prev <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      q_prev <= pipe[STAGES-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] up_mask,
  input  logic [W-1:0] down_mask,
  input  logic         enable,
  input  logic         and_mode,
  output logic         trig
);
  logic [W-1:0] rise_hits, fall_hits, chan_en, level_ok;
  logic         edge_hit, cond_now, cond_prev, level_hit;

  always_comb begin
    rise_hits = cur & ~prev & up_mask & MASK;
    fall_hits = ~cur & prev & down_mask & MASK;
    edge_hit  = |(rise_hits | fall_hits);
    chan_en   = (up_mask | down_mask) & MASK;
    level_ok  = ((cur & up_mask) | (~cur & down_mask)) & chan_en;
    cond_now  = (chan_en != '0) && (level_ok == chan_en);
    level_hit = cond_now && !cond_prev;
    trig      = enable && (and_mode ? level_hit : edge_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) cond_prev <= 1'b0;
    else     cond_prev <= cond_now;
  end
endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
#(
  parameter int           W      = 32,
  parameter int           ADDR_W = 5,
  parameter logic [W-1:0] MASK   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      cur,
  input  logic              trig,
  output logic [W-1:0]      up_mask,
  output logic [W-1:0]      down_mask,
  output logic              enable,
  output logic              and_mode,
  output logic [W-1:0]      status,
  output logic              irq
);
  logic sel_up, sel_down, sel_ctrl, sel_status, sel_input;
  logic ack;
  logic [W-1:0] ctrl_word, rd_mux;

  assign sel_input  = addr == ADDR_W'(OFS_INPUT);
  assign sel_up     = addr == ADDR_W'(OFS_UP);
  assign sel_down   = addr == ADDR_W'(OFS_DOWN);
  assign sel_status = addr == ADDR_W'(OFS_STATUS);
  assign sel_ctrl   = addr == ADDR_W'(OFS_CTRL);
  assign ack        = wr && sel_ctrl && !wdata[CTRL_EN_BIT];

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT]  = enable;
    ctrl_word[CTRL_AND_BIT] = and_mode;
    rd_mux = '0;
    if (sel_input)  rd_mux = cur;
    if (sel_up)     rd_mux = up_mask;
    if (sel_down)   rd_mux = down_mask;
    if (sel_status) rd_mux = status;
    if (sel_ctrl)   rd_mux = ctrl_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_mask   <= '0;
      down_mask <= '0;
      enable    <= 1'b0;
      and_mode  <= 1'b0;
      status    <= '0;
      irq       <= 1'b0;
      rdata     <= '0;
    end else begin
      if (wr && sel_up)   up_mask   <= wdata & MASK;
      if (wr && sel_down) down_mask <= wdata & MASK;
      if (wr && sel_ctrl) begin
        enable   <= wdata[CTRL_EN_BIT];
        and_mode <= wdata[CTRL_AND_BIT];
      end
      if (trig)                  status <= cur & MASK;
      else if (rd && sel_status) status <= '0;
      if (ack)       irq <= 1'b0;
      else if (trig) irq <= 1'b1;
      if (rd) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int CH_LO       = 4,
  parameter int CH_HI       = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pins_in,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);
  localparam logic [DATA_W-1:0] CH_MASK =
    ((ONE << (CH_HI + 1)) - ONE) ^ ((ONE << CH_LO) - ONE);

  logic [DATA_W-1:0] sync_q, prev_q, up_q, down_q, status_q;
  logic              ctrl_en, ctrl_and, trig;

  cos_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(sync_q), .q_prev(prev_q)
  );

  cos_detect #(.W(DATA_W), .MASK(CH_MASK)) u_detect (
    .clk(clk), .rst(rst), .cur(sync_q), .prev(prev_q),
    .up_mask(up_q), .down_mask(down_q), .enable(ctrl_en),
    .and_mode(ctrl_and), .trig(trig)
  );

  cos_regs #(.W(DATA_W), .ADDR_W(ADDR_W), .MASK(CH_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .cur(sync_q), .trig(trig),
    .up_mask(up_q), .down_mask(down_q), .enable(ctrl_en),
    .and_mode(ctrl_and), .status(status_q), .irq(irq)
  );
endmodule

// File: rtl/cos_irq_chk.sv
module cos_irq_chk
  import cos_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter int              ADDR_W = 5,
  parameter logic [DATA_W-1:0] MASK = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              trig,
  input logic              ctrl_en,
  input logic [DATA_W-1:0] status_q
);
  logic ack_wr, mask_rd, status_rd;
  assign ack_wr    = bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && !bus_wdata[CTRL_EN_BIT];
  assign mask_rd   = bus_rd && (bus_addr == ADDR_W'(OFS_UP) || bus_addr == ADDR_W'(OFS_DOWN));
  assign status_rd = bus_rd && bus_addr == ADDR_W'(OFS_STATUS);

  AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    ack_wr |=> !irq); // R8
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack_wr) |=> irq); // R8
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !irq) |=> !irq); // R9
  AST_MASK_READBACK: assert property (@(posedge clk) disable iff (rst)
    mask_rd |=> (bus_rdata & ~MASK) == '0); // R1
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !trig) |=> status_q == '0); // R7
  AST_STATUS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~MASK) == '0); // R7
  AST_TRIG_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (trig && !ack_wr) |=> irq); // R13
endmodule

bind cos_irq_ctrl cos_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MASK(CH_MASK)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .trig(trig),
  .ctrl_en(ctrl_en), .status_q(status_q)
);

// File: tb/test_cos_irq_ctrl.sv
module test_cos_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WIN = 32'h000F_FFF0;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pins = '0;
  logic        irq;
  int total = 0, bad = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  cos_irq_ctrl i_cos_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(posedge clk); #1; d = bus_rdata; bus_rd = 0;
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk); pins = v;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    check("R11 irq", {31'b0, irq}, 32'h0);
    rd(5'h04, rv); check("R11 up", rv, 32'h0);
    rd(5'h0C, rv); check("R11 status", rv, 32'h0);
    rd(5'h10, rv); check("R11 ctrl", rv, 32'h0);
  endtask

  task automatic t_regs;
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, rv); check("R1 up mask", rv, WIN);
    wr(5'h08, 32'hA5A5_A5A5); rd(5'h08, rv); check("R1 down mask", rv, 32'hA5A5_A5A5 & WIN);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, rv); check("R12 ctrl", rv, 32'h6);
    wr(5'h10, 0); wr(5'h04, 0); wr(5'h08, 0);
    drive(32'h1234_5678); rd(5'h00, rv); check("R2 input", rv, 32'h1234_5678);
    check("R9 no irq while off", {31'b0, irq}, 32'h0);
    drive(32'h0);
  endtask

  task automatic t_edge;
    wr(5'h04, 32'h20); wr(5'h08, 32'h400); wr(5'h10, 32'h4);
    drive(32'h0);
    drive(32'h400); check("R4 wrong polarity", {31'b0, irq}, 0);
    drive(32'h404); check("R4 outside window", {31'b0, irq}, 0);
    drive(32'h424); check("R3 rise", {31'b0, irq}, 1);
    rd(5'h0C, rv); check("R7 status capture", rv, 32'h420);
    rd(5'h0C, rv); check("R7 status cleared", rv, 0);
    wr(5'h10, 0); check("R8 ack clears", {31'b0, irq}, 0);
    wr(5'h10, 32'h4);
    drive(32'h024); check("R3 fall", {31'b0, irq}, 1);
    rd(5'h0C, rv);
    drive(32'h004); drive(32'h8024);
    rd(5'h0C, rv); check("R13 status updated", rv, 32'h8020);
    check("R13 irq still high", {31'b0, irq}, 1);
    wr(5'h10, 0); wr(5'h04, 0); wr(5'h08, 0);
    drive(32'h0);
  endtask

  task automatic t_level;
    wr(5'h04, 32'hC0); wr(5'h08, 32'h100); wr(5'h10, 32'h6);
    drive(32'h40);  check("R5 partial", {31'b0, irq}, 0);
    drive(32'hC0);  check("R5 all met", {31'b0, irq}, 1);
    wr(5'h10, 32'h2); wr(5'h10, 32'h6);
    drive(32'hC0);  check("R6 no refire", {31'b0, irq}, 0);
    drive(32'h40);  drive(32'hC0);
    check("R6 refire after drop", {31'b0, irq}, 1);
    wr(5'h10, 0); wr(5'h04, 0); wr(5'h08, 0);
    wr(5'h10, 32'h6);
    drive(32'h0); drive(32'hFFFF_FFFF); drive(32'h0);
    check("R10 empty masks", {31'b0, irq}, 0);
    wr(5'h10, 0);
  endtask

  task automatic t_disabled;
    wr(5'h04, 32'h20); wr(5'h10, 32'h0);
    drive(32'h20); drive(32'h0); drive(32'h20);
    check("R9 disabled", {31'b0, irq}, 0);
    wr(5'h04, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 0;
    t_reset();
    t_regs();
    t_edge();
    t_level();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule